// File: doc/BRIEF.md
# Program Flow Control Unit

This block is the sequencing core of a small processor. It owns the program counter, the 16-bit status word, a hardware return stack, and the loop-end address and loop counter used by zero-overhead hardware loops. Each cycle it takes one sequencing command from the instruction decoder and produces the next program-memory fetch address. The commands are: step, jump, call, return, return from interrupt, interrupt entry, fast interrupt entry, loop start and early loop exit. Instruction decoding, condition-code computation and the memory system sit outside the block.

The status word has a mode byte in bits 15:8 and a condition byte in bits 7:0. The mode byte holds the loop-active flag (bit 15), the forever flag (bit 14), the scaling bits (11:10) and the interrupt mask bits (9:8). Each stack entry is a pair of words: an address half and a data half. A call or an interrupt stores the return address with the status word. A loop start uses two entries, one for the enclosing loop's end address and count and one for the loop start address and status word. Because of this, loop start and loop completion each take two cycles. A debug port gives read and write access to the status word, the loop-end address, the loop counter and the stack level and error flag.

Top module: `flow_ctrl`

## Requirements
- R1: While reset is held and after its release, fetch_addr is 0, sr_out is 16'h0300 (interrupt mask bits 9:8 set, scaling bits, loop flag and forever flag clear), the stack level is 0, the stack error flag is 0, and the loop-end address and loop counter read 0.
- R2: Command codes: 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 return from interrupt, 6 interrupt, 7 fast interrupt, 8 loop start, 9 loop exit. Unlisted codes act as hold. A step makes fetch_addr one higher on the next cycle. A hold leaves every output unchanged.
- R3: A jump or a fast interrupt loads target into fetch_addr. It leaves the stack level and the whole status word unchanged.
- R4: A call pushes the pair {fetch_addr+1, status} and loads target. A return pops one entry into fetch_addr and leaves the status word unchanged.
- R5: An interrupt pushes the pair {current fetch_addr, status}, loads target and sets the mask bits 9:8. A return from interrupt pops one entry and restores both fetch_addr and the complete status word.
- R6: The stack holds DEPTH entries, and stk_level shows how many are in use. A push onto a full stack is discarded and sets the sticky stk_err. A pop from an empty stack yields 0 and also sets stk_err.
- R7: A loop start at fetch address P first pushes the old {loop end, count} and loads the loop end from target and the count from count. On the next cycle it pushes {P+1, status}, sets status bit 15 and moves fetch_addr to P+1. The command offered during that second cycle is ignored.
- R8: A step taken while bit 15 is set, fetch_addr equals the loop end and the counter is not 1 loads fetch_addr from the address half of the top entry and decrements the counter.
- R9: The same step taken with the counter equal to 1 moves fetch_addr to loop end + 1. It pops the top entry and copies only its bit 15 into status bit 15. On the next cycle, with the command ignored, it pops the loop end and count back.
- R10: A loop-exit command performs the R9 exit sequence from any fetch address. With nested loops it therefore leaves bit 15 set and restores the outer loop's end address.
- R11: Debug select 0 is the status word, 1 the loop end, 2 the loop counter and 3 the stack state ({stk_err in bit 15, level in the low bits}). dbg_rdata shows the selected value as it stood before the previous clock edge. A write takes effect only on a hold cycle outside the second cycle of a loop start or exit. A write to select 3 sets the level and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 4 | Sequencing command code |
| target | input | AW | Jump, call, vector or loop-end address |
| count | input | CW | Loop iteration count for loop start |
| dbg_we | input | 1 | Debug write strobe |
| dbg_sel | input | 2 | Debug register select |
| dbg_wdata | input | 16 | Debug write data |
| fetch_addr | output | AW | Next program-memory fetch address |
| sr_out | output | 16 | Status word |
| dbg_rdata | output | 16 | Registered debug read data |
| stk_level | output | $clog2(DEPTH+1) | Stack entries in use |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The commands are driven in several patterns. A plain run of steps and jumps exposes increment and load errors. A call/return pair and an interrupt/return-from-interrupt pair separate a restore of the address alone from a restore of the full status word. A single three-pass loop tests the loop-back and terminal-count decisions. A nested pair closed by loop-exit commands shows whether the loop flag and loop end are taken from the saved state rather than cleared. A run of calls past the depth and returns past empty exercises the sticky error. Debug writes are offered both on hold cycles and under a live command, to tell a gated write from an unconditional one.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_STEP  = 4'd1,
    CMD_JMP   = 4'd2,
    CMD_JSR   = 4'd3,
    CMD_RTS   = 4'd4,
    CMD_RTI   = 4'd5,
    CMD_INT   = 4'd6,
    CMD_FINT  = 4'd7,
    CMD_DO    = 4'd8,
    CMD_ENDDO = 4'd9
  } flow_cmd_e;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_DO2   = 2'd1,
    PH_EXIT2 = 2'd2
  } flow_phase_e;

  localparam int          SR_LOOP  = 15;
  localparam int          SR_IM_HI = 9;
  localparam int          SR_IM_LO = 8;
  localparam logic [15:0] SR_RESET = 16'h0300;

  localparam logic [1:0] SEL_SR  = 2'd0;
  localparam logic [1:0] SEL_LA  = 2'd1;
  localparam logic [1:0] SEL_LC  = 2'd2;
  localparam logic [1:0] SEL_STK = 2'd3;
endpackage

// File: rtl/flow_sys_stack.sv
module flow_sys_stack #(
  parameter int EW    = 32,
  parameter int DEPTH = 15,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] wdata,
  input  logic          set_lvl,
  input  logic [PW-1:0] lvl_in,
  input  logic          err_in,
  output logic [EW-1:0] top,
  output logic [PW-1:0] level,
  output logic          err
);
  logic [EW-1:0] mem [DEPTH];
  logic          full;
  logic          empty;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic [PW-1:0] lvl_m1;

  assign full   = (level == PW'(DEPTH));
  assign empty  = (level == '0);
  assign lvl_m1 = level - 1'b1;
  assign wr_idx = IW'(level);
  assign rd_idx = IW'(lvl_m1);
  assign top    = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      err   <= 1'b0;
    end else if (set_lvl) begin
      level <= (lvl_in > PW'(DEPTH)) ? PW'(DEPTH) : lvl_in;
      err   <= err_in;
    end else if (push) begin
      if (full) err <= 1'b1;
      else      level <= level + 1'b1;
    end else if (pop) begin
      if (empty) err <= 1'b1;
      else       level <= lvl_m1;
    end
  end
endmodule

// File: rtl/flow_loop_eval.sv
module flow_loop_eval #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] la,
  input  logic [CW-1:0] lc,
  input  logic          lf,
  output logic          back,
  output logic          done
);
  logic at_end;
  assign at_end = lf && (pc == la);
  assign back   = at_end && (lc != CW'(1));
  assign done   = at_end && (lc == CW'(1));
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 15,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cmd,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] count,
  input  logic          dbg_we,
  input  logic [1:0]    dbg_sel,
  input  logic [15:0]   dbg_wdata,
  output logic [AW-1:0] fetch_addr,
  output logic [15:0]   sr_out,
  output logic [15:0]   dbg_rdata,
  output logic [PW-1:0] stk_level,
  output logic          stk_err
);
  localparam int LOW = (CW > 16) ? CW : 16;
  localparam int EW  = AW + LOW;

  flow_cmd_e   c;
  flow_phase_e phase, ph_n;
  logic [AW-1:0] pc, pc_n, pc_inc, la, la_n;
  logic [CW-1:0] lc, lc_n;
  logic [15:0]   sr, sr_n;
  logic          in_run;
  logic          st_push, st_pop, st_set;
  logic [EW-1:0] st_wdata, st_top;
  logic [AW-1:0] top_hi;
  logic [LOW-1:0] top_lo;
  logic          lp_back, lp_done;

  assign c      = flow_cmd_e'(cmd);
  assign in_run = (phase == PH_RUN);
  assign pc_inc = pc + 1'b1;
  assign top_hi = st_top[EW-1 -: AW];
  assign top_lo = st_top[LOW-1:0];

  flow_sys_stack #(.EW(EW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(st_push), .pop(st_pop), .wdata(st_wdata),
    .set_lvl(st_set), .lvl_in(dbg_wdata[PW-1:0]), .err_in(dbg_wdata[15]),
    .top(st_top), .level(stk_level), .err(stk_err)
  );

  flow_loop_eval #(.AW(AW), .CW(CW)) u_loop (
    .pc(pc), .la(la), .lc(lc), .lf(sr[SR_LOOP]), .back(lp_back), .done(lp_done)
  );

  always_comb begin
    pc_n     = pc;
    sr_n     = sr;
    la_n     = la;
    lc_n     = lc;
    ph_n     = phase;
    st_push  = 1'b0;
    st_pop   = 1'b0;
    st_set   = 1'b0;
    st_wdata = {pc_inc, LOW'(sr)};
    case (phase)
      PH_DO2: begin
        st_push      = 1'b1;
        st_wdata     = {pc_inc, LOW'(sr)};
        sr_n[SR_LOOP] = 1'b1;
        pc_n         = pc_inc;
        ph_n         = PH_RUN;
      end
      PH_EXIT2: begin
        st_pop = 1'b1;
        la_n   = top_hi;
        lc_n   = top_lo[CW-1:0];
        ph_n   = PH_RUN;
      end
      default: begin
        case (c)
          CMD_STEP: begin
            if (lp_back) begin
              pc_n = top_hi;
              lc_n = lc - 1'b1;
            end else if (lp_done) begin
              pc_n          = pc_inc;
              st_pop        = 1'b1;
              sr_n[SR_LOOP] = top_lo[SR_LOOP];
              ph_n          = PH_EXIT2;
            end else begin
              pc_n = pc_inc;
            end
          end
          CMD_ENDDO: begin
            pc_n          = pc_inc;
            st_pop        = 1'b1;
            sr_n[SR_LOOP] = top_lo[SR_LOOP];
            ph_n          = PH_EXIT2;
          end
          CMD_JMP, CMD_FINT: pc_n = target;
          CMD_JSR: begin
            st_push  = 1'b1;
            st_wdata = {pc_inc, LOW'(sr)};
            pc_n     = target;
          end
          CMD_RTS: begin
            st_pop = 1'b1;
            pc_n   = top_hi;
          end
          CMD_RTI: begin
            st_pop = 1'b1;
            pc_n   = top_hi;
            sr_n   = top_lo[15:0];
          end
          CMD_INT: begin
            st_push  = 1'b1;
            st_wdata = {pc, LOW'(sr)};
            pc_n     = target;
            sr_n[SR_IM_HI:SR_IM_LO] = 2'b11;
          end
          CMD_DO: begin
            st_push  = 1'b1;
            st_wdata = {la, LOW'(lc)};
            la_n     = target;
            lc_n     = count;
            ph_n     = PH_DO2;
          end
          default: begin
            if (dbg_we) begin
              case (dbg_sel)
                SEL_SR:  sr_n = dbg_wdata;
                SEL_LA:  la_n = AW'(dbg_wdata);
                SEL_LC:  lc_n = CW'(dbg_wdata);
                default: st_set = 1'b1;
              endcase
            end
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      sr    <= SR_RESET;
      la    <= '0;
      lc    <= '0;
      phase <= PH_RUN;
    end else begin
      pc    <= pc_n;
      sr    <= sr_n;
      la    <= la_n;
      lc    <= lc_n;
      phase <= ph_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rdata <= '0;
    end else begin
      case (dbg_sel)
        SEL_SR:  dbg_rdata <= sr;
        SEL_LA:  dbg_rdata <= 16'(la);
        SEL_LC:  dbg_rdata <= 16'(lc);
        default: dbg_rdata <= {stk_err, {(15-PW){1'b0}}, stk_level};
      endcase
    end
  end

  assign fetch_addr = pc;
  assign sr_out     = sr;
endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk
  import flow_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 15,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    cmd,
  input logic [AW-1:0] target,
  input logic [AW-1:0] fetch_addr,
  input logic [15:0]   sr_out,
  input logic [PW-1:0] stk_level,
  input logic          stk_err,
  input logic          run
);
  assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_JMP) |=> (fetch_addr == $past(target)));

  assert_fint_no_stack_R3: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_FINT) |=> (stk_level == $past(stk_level) && sr_out == $past(sr_out)));

  assert_int_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_INT) |=> (sr_out[SR_IM_HI:SR_IM_LO] == 2'b11));

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
    stk_level <= PW'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_JSR && stk_level == PW'(DEPTH)) |=> (stk_err && stk_level == PW'(DEPTH)));

  assert_loop_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (run && cmd == CMD_DO) |=> ##1 sr_out[SR_LOOP]);
endmodule

bind flow_ctrl flow_ctrl_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .target(target), .fetch_addr(fetch_addr),
  .sr_out(sr_out), .stk_level(stk_level), .stk_err(stk_err), .run(in_run)
);

// File: tb/flow_ctrl_tb.sv
module flow_ctrl_tb;
  localparam int DEPTH = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cmd = 4'd0;
  logic [15:0] target = '0;
  logic [15:0] count = '0;
  logic        dbg_we = 1'b0;
  logic [1:0]  dbg_sel = '0;
  logic [15:0] dbg_wdata = '0;
  logic [15:0] fetch_addr, sr_out, dbg_rdata;
  logic [3:0]  stk_level;
  logic        stk_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  flow_ctrl u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .target(target), .count(count),
    .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata),
    .fetch_addr(fetch_addr), .sr_out(sr_out), .dbg_rdata(dbg_rdata),
    .stk_level(stk_level), .stk_err(stk_err)
  );

  // reference state, built from the requirements
  logic [15:0] m_pc, m_sr, m_la, m_lc;
  logic [31:0] m_stk [DEPTH];
  int          m_lvl;
  logic        m_err;
  int          m_ph;

  // scoreboard queues
  logic [15:0] q_pc [$];
  logic [15:0] q_sr [$];
  logic [15:0] q_rd [$];
  logic [4:0]  q_st [$];
  string       q_req [$];

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic mpush(input logic [31:0] v);
    if (m_lvl == DEPTH) m_err = 1'b1;
    else begin
      m_stk[m_lvl] = v;
      m_lvl++;
    end
  endtask

  task automatic mpop(output logic [31:0] v);
    if (m_lvl == 0) begin
      m_err = 1'b1;
      v = '0;
    end else begin
      m_lvl--;
      v = m_stk[m_lvl];
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [15:0] t, input logic [15:0] n,
                       input logic we, input logic [1:0] sel, input logic [15:0] wd,
                       input string req);
    logic [15:0] rd;
    logic [31:0] v;
    @(negedge clk);
    cmd = c; target = t; count = n; dbg_we = we; dbg_sel = sel; dbg_wdata = wd;
    case (sel)
      2'd0: rd = m_sr;
      2'd1: rd = m_la;
      2'd2: rd = m_lc;
      default: rd = {m_err, 11'b0, 4'(m_lvl)};
    endcase
    if (m_ph == 1) begin
      mpush({m_pc + 16'd1, m_sr});
      m_sr[15] = 1'b1;
      m_pc = m_pc + 16'd1;
      m_ph = 0;
    end else if (m_ph == 2) begin
      mpop(v);
      m_la = v[31:16];
      m_lc = v[15:0];
      m_ph = 0;
    end else begin
      case (c)
        4'd1: begin
          if (m_sr[15] && m_pc == m_la && m_lc != 16'd1) begin
            m_pc = (m_lvl > 0) ? m_stk[m_lvl-1][31:16] : 16'd0;
            m_lc = m_lc - 16'd1;
          end else if (m_sr[15] && m_pc == m_la) begin
            m_pc = m_pc + 16'd1;
            mpop(v);
            m_sr[15] = v[15];
            m_ph = 2;
          end else m_pc = m_pc + 16'd1;
        end
        4'd9: begin
          m_pc = m_pc + 16'd1;
          mpop(v);
          m_sr[15] = v[15];
          m_ph = 2;
        end
        4'd2, 4'd7: m_pc = t;
        4'd3: begin mpush({m_pc + 16'd1, m_sr}); m_pc = t; end
        4'd4: begin mpop(v); m_pc = v[31:16]; end
        4'd5: begin mpop(v); m_pc = v[31:16]; m_sr = v[15:0]; end
        4'd6: begin mpush({m_pc, m_sr}); m_pc = t; m_sr[9:8] = 2'b11; end
        4'd8: begin mpush({m_la, m_lc}); m_la = t; m_lc = n; m_ph = 1; end
        default: begin
          if (we) begin
            case (sel)
              2'd0: m_sr = wd;
              2'd1: m_la = wd;
              2'd2: m_lc = wd;
              default: begin m_lvl = int'(wd[3:0]); m_err = wd[15]; end
            endcase
          end
        end
      endcase
    end
    q_pc.push_back(m_pc);
    q_sr.push_back(m_sr);
    q_rd.push_back(rd);
    q_st.push_back({m_err, 4'(m_lvl)});
    q_req.push_back(req);
  endtask

  task automatic go(input logic [3:0] c, input logic [15:0] t, input logic [15:0] n, input string req);
    drive(c, t, n, 1'b0, 2'd0, 16'h0, req);
  endtask

  task automatic dbg(input logic we, input logic [1:0] sel, input logic [15:0] wd, input string req);
    drive(4'd0, 16'h0, 16'h0, we, sel, wd, req);
  endtask

  // monitor: compares one expected item per clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (q_req.size() > 0) begin
      string r;
      logic [4:0] st;
      r  = q_req.pop_front();
      st = q_st.pop_front();
      chk(r, "fetch_addr", fetch_addr, q_pc.pop_front());
      chk(r, "sr_out", sr_out, q_sr.pop_front());
      chk(r, "dbg_rdata", dbg_rdata, q_rd.pop_front());
      chk(r, "stk_level/err", {11'b0, stk_err, stk_level}, {11'b0, st});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_pc = '0; m_sr = 16'h0300; m_la = '0; m_lc = '0; m_lvl = 0; m_err = 1'b0; m_ph = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset values while reset is held
    chk("R1", "fetch_addr", fetch_addr, 16'h0000);
    chk("R1", "sr_out", sr_out, 16'h0300);
    chk("R1", "stk_level/err", {11'b0, stk_err, stk_level}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    dbg(1'b0, 2'd1, 16'h0, "R1");
    dbg(1'b0, 2'd2, 16'h0, "R1");
    go(4'd1, 0, 0, "R2"); go(4'd1, 0, 0, "R2"); go(4'd1, 0, 0, "R2");
    go(4'd0, 0, 0, "R2");
    go(4'd15, 0, 0, "R2");
    go(4'd2, 16'h0100, 0, "R3");
    go(4'd7, 16'h0040, 0, "R3");
    go(4'd2, 16'h0200, 0, "R3");
    go(4'd3, 16'h0300, 0, "R4");
    go(4'd1, 0, 0, "R4");
    go(4'd4, 0, 0, "R4");
    dbg(1'b1, 2'd0, 16'h0C55, "R11");
    dbg(1'b0, 2'd0, 16'h0, "R11");
    go(4'd6, 16'h0010, 0, "R5");
    go(4'd1, 0, 0, "R5");
    go(4'd5, 0, 0, "R5");
    drive(4'd1, 16'h0, 16'h0, 1'b1, 2'd1, 16'hBEEF, "R11");
    dbg(1'b0, 2'd1, 16'h0, "R11");

    // single loop: three passes over a three-word body
    go(4'd8, m_pc + 16'd3, 16'd3, "R7");
    go(4'd2, 16'h0F00, 0, "R7");
    dbg(1'b0, 2'd1, 16'h0, "R7");
    for (int i = 0; i < 12; i++) go(4'd1, 0, 0, "R8 R9");
    dbg(1'b0, 2'd3, 16'h0, "R9");
    dbg(1'b0, 2'd2, 16'h0, "R9");

    // nested loops closed by loop-exit commands
    go(4'd8, m_pc + 16'd10, 16'd2, "R7");
    go(4'd0, 0, 0, "R7");
    go(4'd8, m_pc + 16'd4, 16'd2, "R7");
    go(4'd0, 0, 0, "R7");
    go(4'd1, 0, 0, "R8");
    go(4'd1, 0, 0, "R8");
    go(4'd9, 0, 0, "R10");
    go(4'd0, 0, 0, "R10");
    dbg(1'b0, 2'd1, 16'h0, "R10");
    go(4'd9, 0, 0, "R10");
    go(4'd0, 0, 0, "R10");
    dbg(1'b0, 2'd1, 16'h0, "R10");

    // overflow then underflow of the stack
    for (int i = 0; i < DEPTH + 1; i++) go(4'd3, 16'h0400 + 16'(i), 0, "R6");
    dbg(1'b0, 2'd3, 16'h0, "R6");
    for (int i = 0; i < DEPTH + 1; i++) go(4'd4, 0, 0, "R6");
    dbg(1'b0, 2'd3, 16'h0, "R6");
    dbg(1'b1, 2'd3, 16'h0002, "R11");
    dbg(1'b0, 2'd3, 16'h0, "R11");
    dbg(1'b1, 2'd2, 16'h0042, "R11");
    dbg(1'b0, 2'd2, 16'h0, "R11");

    @(negedge clk);
    cmd = 4'd0; dbg_we = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule